// File: doc/BRIEF.md
# Packet DMA Queue Command Controller

This block holds the command state for a packet DMA engine that has one receive channel and two transmit queues (queue 0 is high priority, queue 1 is low priority). A processor writes an 8-bit command word. Each set bit requests an action: enable receive, abort receive, start or stop either transmit queue, or abort transmit. The block tracks whether each queue is started, stopped or running. It presents level requests to the engines and raises a one-cycle end-of-queue pulse when a running queue halts. The same word reads back with the live state.

A stop request does not halt a queue at once. The queue keeps running until the engine reports the end of the frame it is working on. A queue also halts by itself when the engine reaches the end of its descriptor chain. An abort request stays visible in the read-back word until the engine reports idle, so software can poll it. A completed abort closes no descriptor and produces no end-of-queue pulse. A separate counter limits retransmissions of one packet to a programmable number of attempts. A limit of zero means retries never stop.

Top module: `dmaq_cmd_ctrl`

## Requirements
- R1: After reset, `cmd_rdata`, `txq_run`, `txq_stop_req`, `tx_end_irq`, `tx_abort_req`, `rx_run`, `rx_abort_req` and `tx_retry_give_up` are all 0.
- R2: A write with start bit 2+q set and stop bit 4+q clear (q=0 high, q=1 low) has the following effect from the next cycle: read-back bit 2+q is 1, bit 4+q is 0, and `txq_run[q]` is 1.
- R3: A write with stop bit 4+q set has the following effect from the next cycle: read-back bit 4+q is 1 and bit 2+q is 0. This holds even when start bit 2+q is set in the same word.
- R4: A 0 in any start or stop bit of a written word leaves that queue's read-back bits and run state unchanged.
- R5: A stopped queue keeps `txq_run[q]` high, with `txq_stop_req[q]` high, until `tx_frame_done[q]` arrives. In the following cycle the run bit drops and `tx_end_irq[q]` pulses for one cycle. A stop written in the same cycle as a frame end waits for the next frame end.
- R6: `tx_chain_end[q]` on a running queue drops the run bit and start bit 2+q, and pulses `tx_end_irq[q]`. A start write for that queue in the same cycle keeps the queue running with no pulse.
- R7: Abort-transmit (bit 6) stays set in read-back and on `tx_abort_req` while `tx_idle` is low. After a cycle with `tx_idle` high it clears. Both queues' run bits and start bits clear with it, and no `tx_end_irq` pulse is raised.
- R8: Enable-receive (bit 0) stays set after a write until a receive abort completes. Abort-receive (bit 1) holds until `rx_idle` is high. Both bits then clear in the next cycle.
- R9: `tx_retry_give_up` pulses in the cycle after the collision that brings the per-packet retransmit count to a nonzero `retry_limit`. The count then restarts. With a limit of 0 the pulse never occurs.
- R10: A frame end on either queue, or a completed transmit abort, resets the retransmit count. When this falls in the same cycle as a collision, no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 8 | Command word; bits 0 rx enable, 1 rx abort, 2/3 start q0/q1, 4/5 stop q0/q1, 6 tx abort |
| cmd_rdata | output | 8 | Live read-back in the same bit layout |
| tx_frame_done | input | 2 | Engine finished a frame on queue q |
| tx_chain_end | input | 2 | Engine reached the end of queue q's descriptor chain |
| tx_idle | input | 1 | Transmit engine is idle |
| rx_idle | input | 1 | Receive engine is idle |
| tx_collision | input | 1 | A retransmit attempt of the current packet |
| retry_limit | input | RETRY_W | Retransmit limit per packet, 0 means unlimited |
| txq_run | output | 2 | Queue q is being served |
| txq_stop_req | output | 2 | Stop pending at the next frame end of queue q |
| tx_end_irq | output | 2 | One-cycle end-of-queue pulse |
| tx_abort_req | output | 1 | Transmit abort requested |
| rx_run | output | 1 | Receive enabled |
| rx_abort_req | output | 1 | Receive abort requested |
| tx_retry_give_up | output | 1 | Close the packet with a retransmit-limit error |

## Verification
Two kinds of event can land in one cycle. A processor write to a queue can coincide with the engine's frame-end or chain-end report for that queue. A collision can coincide with a frame end or an abort completion. The bench sets these up directly: a start written together with a chain end, a stop written together with a frame end, and a collision together with a frame end. It then checks the run bit, the end-of-queue pulse and the give-up pulse in the cycle that follows. A long random run then drives writes, engine reports and idle levels with independent probabilities, so these overlaps recur many times. Every cycle is compared against a reference model in the bench.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  localparam int CMD_W   = 8;
  localparam int NUM_TXQ = 2;

  localparam int B_RX_EN  = 0;
  localparam int B_RX_AB  = 1;
  localparam int B_START0 = 2;
  localparam int B_STOP0  = B_START0 + NUM_TXQ;
  localparam int B_TX_AB  = B_STOP0 + NUM_TXQ;

  typedef struct packed {
    logic start;
    logic stop;
    logic run;
    logic irq;
  } txq_stat_t;
endpackage

// File: rtl/dmaq_abort_unit.sv
module dmaq_abort_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_abort,
  input  logic idle,
  output logic pend_q,
  output logic done
);
  assign done = pend_q & idle;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= (pend_q & ~idle) | wr_abort;
  end
endmodule

// File: rtl/dmaq_txq_ctrl.sv
module dmaq_txq_ctrl
  import dmaq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_start,
  input  logic      wr_stop,
  input  logic      frame_done,
  input  logic      chain_end,
  input  logic      abort_done,
  output txq_stat_t stat
);
  logic start_q, stop_q, run_q, irq_q;
  logic start_take, ev_chain, ev_stop;

  assign start_take = wr_start & ~wr_stop;
  assign ev_chain   = run_q & ~start_take & chain_end;
  assign ev_stop    = run_q & ~start_take & ~chain_end & stop_q & frame_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      run_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (abort_done) begin
        run_q   <= 1'b0;
        start_q <= 1'b0;
      end else begin
        if (wr_stop) begin
          stop_q  <= 1'b1;
          start_q <= 1'b0;
        end else if (start_take) begin
          start_q <= 1'b1;
          stop_q  <= 1'b0;
          run_q   <= 1'b1;
        end
        if (ev_chain || ev_stop) begin
          run_q <= 1'b0;
          irq_q <= 1'b1;
        end
        if (ev_chain) start_q <= 1'b0;
      end
    end
  end

  assign stat = '{start: start_q, stop: stop_q, run: run_q, irq: irq_q};
endmodule

// File: rtl/dmaq_retry_limiter.sv
module dmaq_retry_limiter #(
  parameter int RETRY_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RETRY_W-1:0] limit,
  input  logic               collision,
  input  logic               pkt_end,
  output logic               give_up_q
);
  localparam logic [RETRY_W-1:0] CNT_MAX = '1;

  function automatic logic limit_reached(input logic [RETRY_W-1:0] cnt,
                                         input logic [RETRY_W-1:0] lim);
    logic [RETRY_W:0] next_cnt;
    next_cnt = {1'b0, cnt} + 1'b1;
    return (lim != '0) && (next_cnt >= {1'b0, lim});
  endfunction

  function automatic logic [RETRY_W-1:0] sat_inc(input logic [RETRY_W-1:0] cnt);
    return (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
  endfunction

  logic [RETRY_W-1:0] cnt_q;
  logic               hit;

  assign hit = collision & ~pkt_end & limit_reached(cnt_q, limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      give_up_q <= 1'b0;
    end else begin
      give_up_q <= hit;
      if (pkt_end || hit) cnt_q <= '0;
      else if (collision) cnt_q <= sat_inc(cnt_q);
    end
  end
endmodule

// File: rtl/dmaq_cmd_ctrl.sv
module dmaq_cmd_ctrl
  import dmaq_pkg::*;
#(
  parameter int RETRY_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic [CMD_W-1:0]   cmd_wdata,
  output logic [CMD_W-1:0]   cmd_rdata,
  input  logic [NUM_TXQ-1:0] tx_frame_done,
  input  logic [NUM_TXQ-1:0] tx_chain_end,
  input  logic               tx_idle,
  input  logic               rx_idle,
  input  logic               tx_collision,
  input  logic [RETRY_W-1:0] retry_limit,
  output logic [NUM_TXQ-1:0] txq_run,
  output logic [NUM_TXQ-1:0] txq_stop_req,
  output logic [NUM_TXQ-1:0] tx_end_irq,
  output logic               tx_abort_req,
  output logic               rx_run,
  output logic               rx_abort_req,
  output logic               tx_retry_give_up
);
  // named internal events
  logic tx_abort_done, rx_abort_done, pkt_end;
  logic wr_tx_abort, wr_rx_abort, wr_rx_en;
  logic rx_en_q;
  txq_stat_t q_stat [NUM_TXQ];

  assign wr_tx_abort = cmd_wr & cmd_wdata[B_TX_AB];
  assign wr_rx_abort = cmd_wr & cmd_wdata[B_RX_AB];
  assign wr_rx_en    = cmd_wr & cmd_wdata[B_RX_EN];
  assign pkt_end     = (|tx_frame_done) | tx_abort_done;

  dmaq_abort_unit tx_ab_i (
    .clk(clk), .rst_n(rst_n), .wr_abort(wr_tx_abort), .idle(tx_idle),
    .pend_q(tx_abort_req), .done(tx_abort_done)
  );

  dmaq_abort_unit rx_ab_i (
    .clk(clk), .rst_n(rst_n), .wr_abort(wr_rx_abort), .idle(rx_idle),
    .pend_q(rx_abort_req), .done(rx_abort_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)             rx_en_q <= 1'b0;
    else if (rx_abort_done) rx_en_q <= 1'b0;
    else if (wr_rx_en)      rx_en_q <= 1'b1;
  end
  assign rx_run = rx_en_q;

  for (genvar q = 0; q < NUM_TXQ; q++) begin : g_txq
    logic wr_start, wr_stop;
    assign wr_start = cmd_wr & cmd_wdata[B_START0+q];
    assign wr_stop  = cmd_wr & cmd_wdata[B_STOP0+q];

    dmaq_txq_ctrl q_i (
      .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_stop(wr_stop),
      .frame_done(tx_frame_done[q]), .chain_end(tx_chain_end[q]),
      .abort_done(tx_abort_done), .stat(q_stat[q])
    );

    assign txq_run[q]      = q_stat[q].run;
    assign txq_stop_req[q] = q_stat[q].run & q_stat[q].stop;
    assign tx_end_irq[q]   = q_stat[q].irq;
  end

  dmaq_retry_limiter #(.RETRY_W(RETRY_W)) retry_i (
    .clk(clk), .rst_n(rst_n), .limit(retry_limit), .collision(tx_collision),
    .pkt_end(pkt_end), .give_up_q(tx_retry_give_up)
  );

  always_comb begin
    cmd_rdata          = '0;
    cmd_rdata[B_RX_EN] = rx_en_q;
    cmd_rdata[B_RX_AB] = rx_abort_req;
    cmd_rdata[B_TX_AB] = tx_abort_req;
    for (int q = 0; q < NUM_TXQ; q++) begin
      cmd_rdata[B_START0+q] = q_stat[q].start;
      cmd_rdata[B_STOP0+q]  = q_stat[q].stop;
    end
  end
endmodule

// File: rtl/dmaq_cmd_ctrl_chk.sv
module dmaq_cmd_ctrl_chk
  import dmaq_pkg::*;
#(
  parameter int RETRY_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_wr,
  input logic [CMD_W-1:0]   cmd_wdata,
  input logic [CMD_W-1:0]   cmd_rdata,
  input logic [NUM_TXQ-1:0] tx_frame_done,
  input logic               tx_idle,
  input logic               rx_idle,
  input logic               tx_collision,
  input logic [RETRY_W-1:0] retry_limit,
  input logic [NUM_TXQ-1:0] txq_run,
  input logic [NUM_TXQ-1:0] tx_end_irq,
  input logic               tx_abort_req,
  input logic               rx_run,
  input logic               rx_abort_req,
  input logic               tx_retry_give_up,
  input logic               tx_abort_done
);
  for (genvar q = 0; q < NUM_TXQ; q++) begin : g_q
    assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && cmd_wdata[B_START0+q] && !cmd_wdata[B_STOP0+q] && !tx_abort_done
      |=> txq_run[q] && cmd_rdata[B_START0+q] && !cmd_rdata[B_STOP0+q]);

    assert_stop_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && cmd_wdata[B_STOP0+q] && !tx_abort_done
      |=> cmd_rdata[B_STOP0+q] && !cmd_rdata[B_START0+q]);

    assert_irq_on_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_end_irq[q] |-> !txq_run[q] && $past(txq_run[q]));
  end

  assert_tx_abort_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort_req && tx_idle && !(cmd_wr && cmd_wdata[B_TX_AB])
    |=> !tx_abort_req && txq_run == '0 && tx_end_irq == '0);

  assert_rx_abort_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_abort_req && rx_idle && !(cmd_wr && cmd_wdata[B_RX_AB])
    |=> !rx_abort_req && !rx_run);

  assert_giveup_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_retry_give_up |-> $past(tx_collision) && $past(retry_limit) != '0);

  assert_end_beats_collision_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|tx_frame_done) && tx_collision |=> !tx_retry_give_up);
endmodule

bind dmaq_cmd_ctrl dmaq_cmd_ctrl_chk #(.RETRY_W(RETRY_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
  .cmd_rdata(cmd_rdata), .tx_frame_done(tx_frame_done), .tx_idle(tx_idle),
  .rx_idle(rx_idle), .tx_collision(tx_collision), .retry_limit(retry_limit),
  .txq_run(txq_run), .tx_end_irq(tx_end_irq), .tx_abort_req(tx_abort_req),
  .rx_run(rx_run), .rx_abort_req(rx_abort_req),
  .tx_retry_give_up(tx_retry_give_up), .tx_abort_done(tx_abort_done)
);

// File: tb/dmaq_cmd_ctrl_tb.sv
module dmaq_cmd_ctrl_tb_top;
  localparam int RW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0;
  logic [7:0] cmd_wdata = '0;
  logic [7:0] cmd_rdata;
  logic [1:0] tx_frame_done = '0, tx_chain_end = '0;
  logic tx_idle = 1'b0, rx_idle = 1'b0, tx_collision = 1'b0;
  logic [RW-1:0] retry_limit = '0;
  logic [1:0] txq_run, txq_stop_req, tx_end_irq;
  logic tx_abort_req, rx_run, rx_abort_req, tx_retry_give_up;

  always #4 clk = ~clk;

  dmaq_cmd_ctrl #(.RETRY_W(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .tx_frame_done(tx_frame_done),
    .tx_chain_end(tx_chain_end), .tx_idle(tx_idle), .rx_idle(rx_idle),
    .tx_collision(tx_collision), .retry_limit(retry_limit), .txq_run(txq_run),
    .txq_stop_req(txq_stop_req), .tx_end_irq(tx_end_irq),
    .tx_abort_req(tx_abort_req), .rx_run(rx_run), .rx_abort_req(rx_abort_req),
    .tx_retry_give_up(tx_retry_give_up)
  );

  int n_cmp = 0, n_bad = 0;

  // reference state
  logic [1:0] m_start = '0, m_stop = '0, m_act = '0, m_irq = '0;
  logic m_rxen = 0, m_rxab = 0, m_txab = 0, m_gu = 0;
  int   m_cnt = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rdata();
    return {1'b0, m_txab, m_stop[1], m_stop[0], m_start[1], m_start[0], m_rxab, m_rxen};
  endfunction

  function automatic bit retry_hit(int cnt, int lim);
    return (lim != 0) && (cnt + 1 >= lim);
  endfunction

  task automatic model_edge();
    logic [1:0] ns = m_start, np = m_stop, na = m_act, ni = '0;
    logic txd = m_txab & tx_idle;
    logic rxd = m_rxab & rx_idle;
    for (int q = 0; q < 2; q++) begin
      logic st = cmd_wr & cmd_wdata[2+q];
      logic sp = cmd_wr & cmd_wdata[4+q];
      if (txd) begin na[q] = 0; ns[q] = 0; end
      else begin
        if (sp) begin np[q] = 1; ns[q] = 0; end
        else if (st) begin ns[q] = 1; np[q] = 0; na[q] = 1; end
        if (m_act[q] && !(st && !sp)) begin
          if (tx_chain_end[q]) begin na[q] = 0; ns[q] = 0; ni[q] = 1; end
          else if (m_stop[q] && tx_frame_done[q]) begin na[q] = 0; ni[q] = 1; end
        end
      end
    end
    m_gu = 0;
    if ((|tx_frame_done) || txd) m_cnt = 0;
    else if (tx_collision) begin
      if (retry_hit(m_cnt, int'(retry_limit))) begin m_cnt = 0; m_gu = 1; end
      else if (m_cnt < 15) m_cnt++;
    end
    m_rxen = rxd ? 1'b0 : (m_rxen | (cmd_wr & cmd_wdata[0]));
    m_rxab = (m_rxab & ~rx_idle) | (cmd_wr & cmd_wdata[1]);
    m_txab = (m_txab & ~tx_idle) | (cmd_wr & cmd_wdata[6]);
    m_start = ns; m_stop = np; m_act = na; m_irq = ni;
  endtask

  task automatic compare_all();
    check("R2/R3 readback", cmd_rdata, exp_rdata());
    check("R5/R6 run", txq_run, m_act);
    check("R5 stop_req", txq_stop_req, m_stop & m_act);
    check("R5/R6 irq", tx_end_irq, m_irq);
    check("R7 tx abort", tx_abort_req, m_txab);
    check("R8 rx run", rx_run, m_rxen);
    check("R8 rx abort", rx_abort_req, m_rxab);
    check("R9 give up", tx_retry_give_up, m_gu);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic drv(logic wr, logic [7:0] wd, logic [1:0] fd, logic [1:0] ce,
                     logic ti, logic ri, logic col);
    cmd_wr = wr; cmd_wdata = wd; tx_frame_done = fd; tx_chain_end = ce;
    tx_idle = ti; rx_idle = ri; tx_collision = col;
    step();
  endtask

  task automatic quiet(); drv(0, 8'h00, 2'b00, 2'b00, 0, 0, 0); endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", cmd_rdata, 0);
    check("R1 outputs", {txq_run, txq_stop_req, tx_end_irq, tx_abort_req, rx_run,
                         rx_abort_req, tx_retry_give_up}, 0);

    drv(1, 8'h04, 0, 0, 0, 0, 0);            // R2 start high
    check("R2 rdata", cmd_rdata, 8'h04);
    check("R2 run", txq_run, 2'b01);
    drv(1, 8'h00, 0, 0, 0, 0, 0);            // R4 zero write
    check("R4 rdata", cmd_rdata, 8'h04);
    drv(1, 8'h10, 0, 0, 0, 0, 0);            // R3 stop high, R5 still running
    check("R3 rdata", cmd_rdata, 8'h10);
    check("R5 run held", {txq_run, txq_stop_req}, 4'b0101);
    drv(0, 0, 2'b01, 0, 0, 0, 0);            // R5 frame end
    check("R5 halt", {txq_run, tx_end_irq}, 4'b0001);
    quiet();
    check("R5 pulse one cycle", tx_end_irq, 0);
    drv(1, 8'h28, 0, 0, 0, 0, 0);            // R3 start+stop low: stop wins
    check("R3 same-word", cmd_rdata, 8'h30);
    check("R3 no run", txq_run, 0);
    drv(1, 8'h08, 0, 0, 0, 0, 0);            // start low
    check("R2 low", {cmd_rdata, txq_run}, {8'h18, 2'b10});
    drv(1, 8'h08, 0, 2'b10, 0, 0, 0);        // R6 start with chain end
    check("R6 start beats chain end", {txq_run, tx_end_irq}, 4'b1000);
    drv(0, 0, 0, 2'b10, 0, 0, 0);            // R6 chain end
    check("R6 chain halt", {txq_run, tx_end_irq}, 4'b0010);
    check("R6 start cleared", cmd_rdata, 8'h10);
    drv(1, 8'h04, 0, 0, 0, 0, 0);
    drv(1, 8'h10, 2'b01, 0, 0, 0, 0);        // R5 stop together with frame end
    check("R5 stop waits", {txq_run, tx_end_irq}, 4'b0100);
    drv(0, 0, 2'b01, 0, 0, 0, 0);
    check("R5 stop next frame", {txq_run, tx_end_irq}, 4'b0001);
    drv(1, 8'h0C, 0, 0, 0, 0, 0);            // start both
    drv(1, 8'h40, 0, 0, 0, 0, 0);            // R7 abort tx
    check("R7 pending", {tx_abort_req, cmd_rdata[6]}, 2'b11);
    quiet();
    check("R7 held", tx_abort_req, 1);
    drv(0, 0, 0, 0, 1, 0, 0);
    check("R7 cleared", {tx_abort_req, txq_run, tx_end_irq, cmd_rdata[3:2]}, 0);
    drv(1, 8'h01, 0, 0, 0, 0, 0);            // R8 rx enable
    check("R8 rx on", rx_run, 1);
    drv(1, 8'h02, 0, 0, 0, 0, 0);
    check("R8 rx abort held", {rx_run, rx_abort_req}, 2'b11);
    drv(0, 0, 0, 0, 0, 1, 0);
    check("R8 rx abort done", {rx_run, rx_abort_req, cmd_rdata[1:0]}, 0);

    retry_limit = 4'd3;                      // R9 limit of three
    drv(0, 0, 0, 0, 0, 0, 1);
    drv(0, 0, 0, 0, 0, 0, 1);
    check("R9 below limit", tx_retry_give_up, 0);
    drv(0, 0, 0, 0, 0, 0, 1);
    check("R9 at limit", tx_retry_give_up, 1);
    quiet();
    check("R9 pulse one cycle", tx_retry_give_up, 0);
    retry_limit = 4'd0;                      // R9 unlimited
    for (int i = 0; i < 20; i++) begin
      drv(0, 0, 0, 0, 0, 0, 1);
      check("R9 unlimited", tx_retry_give_up, 0);
    end
    retry_limit = 4'd2;                      // R10 frame end with collision
    drv(0, 0, 2'b01, 0, 0, 0, 0);
    drv(0, 0, 0, 0, 0, 0, 1);
    drv(0, 0, 2'b10, 0, 0, 0, 1);
    check("R10 end beats collision", tx_retry_give_up, 0);
    drv(0, 0, 0, 0, 0, 0, 1);
    check("R10 count restarted", tx_retry_give_up, 0);
    drv(0, 0, 0, 0, 0, 0, 1);
    check("R10 limit after restart", tx_retry_give_up, 1);

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] wd;
      if (i % 400 == 0) retry_limit = RW'($urandom_range(0, 5));
      wd = 8'($urandom) & 8'h7F;
      drv(($urandom_range(0, 5) == 0), wd,
          {($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0)},
          {($urandom_range(0, 19) == 0), ($urandom_range(0, 19) == 0)},
          ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
          ($urandom_range(0, 2) == 0));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule